// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial PCM stream into parallel 24-bit left and right samples. The stream is a bit clock, a frame clock and one or two data lines, all brought into the system clock domain by the surrounding logic. The block watches for rising edges of the bit clock and samples the data and frame clock on each of them. Samples arrive most significant bit first in two's complement. Words of 16, 18, 20 or 24 bits are accepted and sign-extended to 24 bits.

Four framing conventions are decoded on a single shared data line: left-justified, I2S, right-justified and a DSP-style mode with a one-bit frame pulse. A separate dual-line mode takes left and right words on two data lines in parallel, framed by a word clock. This is the arrangement used when an external interpolation filter feeds the receiver. A strobe marks each completed stereo frame. Each channel has a zero detector that flags a long run of silent samples.

Top module: `sar_rx`

## Requirements
- R1: With `fmt_i`=0 (left-justified), a high frame clock marks the left word and a low one the right word. The bit sampled at a frame clock change is the MSB.
- R2: With `fmt_i`=1 (I2S), a low frame clock marks the left word. The MSB is the bit sampled one bit clock after the frame clock change.
- R3: With `fmt_i`=2 (right-justified), a high frame clock marks the left word. The word's LSB is the last bit sampled before the frame clock changes, and only the final N bits of the half-frame are kept.
- R4: With `fmt_i`=3 (DSP), the frame clock is a one-bit high pulse. The left MSB is sampled on the next bit clock, and the right word follows directly after the N left bits.
- R5: `wlen_i` selects the word length N: 0=16, 1=18, 2=20, 3=24 bits. The N-bit word is sign-extended to 24 bits, and any bits in a slot beyond the word are ignored.
- R6: With `dual_i`=1, a rising edge of the word clock marks the MSB of both words. `sdata_a_i` carries left, `sdata_b_i` carries right, and `fmt_i` is ignored.
- R7: `valid_o` is high for exactly one system clock once per stereo frame, in the cycle after the bit clock edge that completes the right word. `left_o` and `right_o` change only after a bit clock rising edge.
- R8: A channel's zero flag rises once `ZERO_RUN` consecutive samples of that channel are zero. It stays high through further zero samples and falls on the first non-zero sample.
- R9: While `rst_n` is low, both samples, the strobe and both zero flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Framing convention: 0 left-justified, 1 I2S, 2 right-justified, 3 DSP |
| wlen_i | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| dual_i | input | 1 | Dual data line mode |
| bclk_i | input | 1 | Serial bit clock, synchronous to clk |
| fclk_i | input | 1 | Frame clock, frame pulse or word clock |
| sdata_a_i | input | 1 | Serial data (left line in dual mode) |
| sdata_b_i | input | 1 | Right data line in dual mode |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle stereo frame strobe |
| zero_l_o | output | 1 | Left channel zero flag |
| zero_r_o | output | 1 | Right channel zero flag |

## Verification
In dual-line mode, the left word, the right word, the frame strobe and both zero detectors all complete on the same bit clock edge. The right-justified mode also closes one word on the very bit that opens the next. The bench provokes the first case with full and short dual-line frames. It judges each by reading both samples at the single strobe and comparing them to sign-extended values computed from the table. The zero-run test then runs zero samples on one channel while the other channel stays busy, so that a flag change and a strobe land together.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = 6;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } sar_fmt_e;

    // word length code to bit count
    function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    word_bits = CNT_W'(16);
            2'd1:    word_bits = CNT_W'(18);
            2'd2:    word_bits = CNT_W'(20);
            default: word_bits = CNT_W'(24);
        endcase
    endfunction

    // keep the low N bits and extend their sign to the full sample width
    function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] v,
                                                      input logic [1:0] code);
        case (code)
            2'd0:    sign_fill = {{8{v[15]}}, v[15:0]};
            2'd1:    sign_fill = {{6{v[17]}}, v[17:0]};
            2'd2:    sign_fill = {{4{v[19]}}, v[19:0]};
            default: sign_fill = v;
        endcase
    endfunction

endpackage

// File: rtl/sar_bit_sampler.sv
module sar_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fclk_i,
    input  logic sd_a_i,
    input  logic sd_b_i,
    output logic bit_en_o,
    output logic f_now_o,
    output logic f_prev_o,
    output logic a_bit_o,
    output logic b_bit_o
);

    typedef struct packed {
        logic bclk;
        logic fprev;
    } smp_state_t;

    smp_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.bclk = bclk_i;
        if (bclk_i && !s_q.bclk) begin
            s_d.fprev = fclk_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_en_o = bclk_i && !s_q.bclk;
    assign f_now_o  = fclk_i;
    assign f_prev_o = s_q.fprev;
    assign a_bit_o  = sd_a_i;
    assign b_bit_o  = sd_b_i;

    // R7: a bit event never spans two system clocks
    p_single_bit_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_o |=> !bit_en_o);

endmodule

// File: rtl/sar_zero_det.sv
module sar_zero_det #(
    parameter int ZERO_RUN = 1024,
    parameter int WORD_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en_i,
    input  logic [WORD_W-1:0] smp_i,
    output logic              zero_o
);

    localparam int RUN_W = $clog2(ZERO_RUN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             flag;
    } zd_state_t;

    zd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (smp_en_i) begin
            if (smp_i == '0) begin
                if (s_q.run != RUN_W'(ZERO_RUN)) begin
                    s_d.run = s_q.run + 1'b1;
                end
                s_d.flag = (s_d.run == RUN_W'(ZERO_RUN));
            end else begin
                s_d.run  = '0;
                s_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign zero_o = s_q.flag;

    p_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en_i && smp_i != '0) |=> !zero_o);

    p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en_i |=> $stable(zero_o));

endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
    parameter int ZERO_RUN = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  fmt_i,
    input  logic [1:0]  wlen_i,
    input  logic        dual_i,
    input  logic        bclk_i,
    input  logic        fclk_i,
    input  logic        sdata_a_i,
    input  logic        sdata_b_i,
    output logic [23:0] left_o,
    output logic [23:0] right_o,
    output logic        valid_o,
    output logic        zero_l_o,
    output logic        zero_r_o
);
    import sar_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] sha;
        logic [SAMPLE_W-1:0] shb;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } rx_state_t;

    rx_state_t s_d, s_q;

    logic bit_en, f_now, f_prev, a_bit, b_bit;
    logic                left_en, right_en;
    logic [SAMPLE_W-1:0] left_w, right_w;

    sar_bit_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk_i),
        .fclk_i   (fclk_i),
        .sd_a_i   (sdata_a_i),
        .sd_b_i   (sdata_b_i),
        .bit_en_o (bit_en),
        .f_now_o  (f_now),
        .f_prev_o (f_prev),
        .a_bit_o  (a_bit),
        .b_bit_o  (b_bit)
    );

    always_comb begin
        logic [CNT_W-1:0]    nb;
        logic [CNT_W-1:0]    idx;
        logic [SAMPLE_W-1:0] sha_n, shb_n;
        logic                start, left_half;

        s_d       = s_q;
        s_d.valid = 1'b0;
        left_en   = 1'b0;
        right_en  = 1'b0;
        left_w    = '0;
        right_w   = '0;
        nb        = word_bits(wlen_i);
        sha_n     = {s_q.sha[SAMPLE_W-2:0], a_bit};
        shb_n     = {s_q.shb[SAMPLE_W-2:0], b_bit};

        if (dual_i) begin
            start = f_now && !f_prev;
        end else if (fmt_i == FMT_DSP) begin
            start = f_now;
        end else begin
            start = f_now ^ f_prev;
        end
        idx       = start ? '0 : ((s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1);
        left_half = (fmt_i == FMT_I2S) ? !f_now : f_now;

        if (bit_en) begin
            s_d.sha = sha_n;
            s_d.shb = shb_n;
            s_d.cnt = idx;
            if (dual_i) begin
                if (idx == nb - 1'b1) begin
                    left_en  = 1'b1;
                    right_en = 1'b1;
                    left_w   = sign_fill(sha_n, wlen_i);
                    right_w  = sign_fill(shb_n, wlen_i);
                end
            end else begin
                case (fmt_i)
                    FMT_LJ, FMT_I2S: begin
                        if (idx == ((fmt_i == FMT_LJ) ? nb - 1'b1 : nb)) begin
                            if (left_half) begin
                                left_en = 1'b1;
                                left_w  = sign_fill(sha_n, wlen_i);
                            end else begin
                                right_en = 1'b1;
                                right_w  = sign_fill(sha_n, wlen_i);
                            end
                        end
                    end
                    FMT_RJ: begin
                        // the word just closed lies in the bits before this edge
                        if (start) begin
                            if (f_prev) begin
                                left_en = 1'b1;
                                left_w  = sign_fill(s_q.sha, wlen_i);
                            end else begin
                                right_en = 1'b1;
                                right_w  = sign_fill(s_q.sha, wlen_i);
                            end
                        end
                    end
                    default: begin
                        if (idx == nb) begin
                            left_en = 1'b1;
                            left_w  = sign_fill(sha_n, wlen_i);
                        end
                        if (idx == {nb[CNT_W-2:0], 1'b0}) begin
                            right_en = 1'b1;
                            right_w  = sign_fill(sha_n, wlen_i);
                        end
                    end
                endcase
            end
        end

        if (left_en) begin
            s_d.left = left_w;
        end
        if (right_en) begin
            s_d.right = right_w;
            s_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= CNT_MAX;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_zero
            logic zf;
            sar_zero_det #(
                .ZERO_RUN (ZERO_RUN),
                .WORD_W   (SAMPLE_W)
            ) u_zero (
                .clk      (clk),
                .rst_n    (rst_n),
                .smp_en_i ((ch == 0) ? left_en : right_en),
                .smp_i    ((ch == 0) ? left_w : right_w),
                .zero_o   (zf)
            );
        end
    endgenerate

    assign zero_l_o = g_zero[0].zf;
    assign zero_r_o = g_zero[1].zf;
    assign left_o   = s_q.left;
    assign right_o  = s_q.right;
    assign valid_o  = s_q.valid;

    p_valid_from_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_en));

    p_samples_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(left_o) && $stable(right_o)));

    p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: tb/sar_rx_tb.sv
`timescale 1ns/1ps
module sar_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd3;
    logic        dual = 1'b0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sda = 1'b0;
    logic        sdb = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o, zero_l, zero_r;

    int          n_chk = 0;
    int          n_bad = 0;
    int          n_valid = 0;
    logic [23:0] cap_l = '0, cap_r = '0;

    always #2 clk = ~clk;

    sar_rx #(.ZERO_RUN(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt),
        .wlen_i    (wlen),
        .dual_i    (dual),
        .bclk_i    (bclk),
        .fclk_i    (fclk),
        .sdata_a_i (sda),
        .sdata_b_i (sdb),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .zero_l_o  (zero_l),
        .zero_r_o  (zero_r)
    );

    always @(negedge clk) begin
        if (valid_o) begin
            cap_l = left_o;
            cap_r = right_o;
            n_valid++;
        end
    end

    // {fmt, wlen, dual, left, right}
    localparam logic [52:0] VEC [13] = '{
        {2'd0, 2'd3, 1'b0, 24'h123456, 24'hFEDCBA},
        {2'd0, 2'd0, 1'b0, 24'h008001, 24'h007FFF},
        {2'd1, 2'd3, 1'b0, 24'hA5A5A5, 24'h5A5A5A},
        {2'd1, 2'd1, 1'b0, 24'h020001, 24'h01FFFF},
        {2'd2, 2'd3, 1'b0, 24'h800000, 24'h7FFFFF},
        {2'd2, 2'd2, 1'b0, 24'h080000, 24'h012345},
        {2'd2, 2'd0, 1'b0, 24'h001234, 24'h00F00F},
        {2'd3, 2'd3, 1'b0, 24'h3C3C3C, 24'hC3C3C3},
        {2'd3, 2'd2, 1'b0, 24'h0ABCDE, 24'h054321},
        {2'd2, 2'd3, 1'b1, 24'h111111, 24'h999999},
        {2'd1, 2'd1, 1'b1, 24'h03FFFF, 24'h000002},
        {2'd1, 2'd0, 1'b0, 24'h00FFFF, 24'h000001},
        {2'd0, 2'd2, 1'b0, 24'h07FFFF, 24'h000001}
    };

    function automatic int nbits(input logic [1:0] w);
        case (w)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] sx(input logic [23:0] v, input int n);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic f, input logic a, input logic b);
        bclk = 1'b0; fclk = f; sda = a; sdb = b;
        @(negedge clk); @(negedge clk);
        bclk = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] f, input logic [1:0] w, input logic d,
                              input logic [23:0] lv, input logic [23:0] rv);
        int n;
        n = nbits(w);
        if (d) begin
            for (int i = 0; i < 32; i++)
                send_bit(i < 16, (i < n) ? lv[n-1-i] : 1'b1, (i < n) ? rv[n-1-i] : 1'b1);
        end else if (f == 2'd3) begin
            for (int i = 0; i < 64; i++)
                send_bit(i == 0,
                         (i >= 1 && i <= n) ? lv[n-i] :
                         (i > n && i <= 2*n) ? rv[2*n-i] : 1'b1, 1'b0);
        end else begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] wv;
                wv = (h == 0) ? lv : rv;
                for (int i = 0; i < 32; i++) begin
                    if (f == 2'd0)
                        send_bit(h == 0, (i < n) ? wv[n-1-i] : 1'b1, 1'b0);
                    else if (f == 2'd1)
                        send_bit(h == 1, (i >= 1 && i <= n) ? wv[n-i] : 1'b1, 1'b0);
                    else
                        send_bit(h == 0, (i >= 32-n) ? wv[31-i] : 1'b1, 1'b0);
                end
            end
        end
    endtask

    task automatic lead_in(input logic [1:0] f, input logic d);
        for (int i = 0; i < 4; i++) send_bit(!d && f == 2'd1, 1'b1, 1'b1);
    endtask

    task automatic trail(input logic [1:0] f, input logic d);
        for (int i = 0; i < 2; i++) send_bit(d || f == 2'd0 || f == 2'd2, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 left at reset", left_o, 24'h0);
        chk("R9 right at reset", right_o, 24'h0);
        chk("R9 strobe/flags at reset", {21'd0, valid_o, zero_l, zero_r}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1..R6 by format, R5 by length
        for (int v = 0; v < 13; v++) begin
            logic [1:0]  vf, vw;
            logic        vd;
            logic [23:0] vl, vr;
            string       tag;
            {vf, vw, vd, vl, vr} = VEC[v];
            fmt = vf; wlen = vw; dual = vd;
            tag = vd ? "R6 dual" : (vf == 0) ? "R1 LJ" : (vf == 1) ? "R2 I2S" :
                  (vf == 2) ? "R3 RJ" : "R4 DSP";
            n_valid = 0;
            lead_in(vf, vd);
            for (int k = 0; k < 3; k++) send_frame(vf, vw, vd, vl, vr);
            trail(vf, vd);
            repeat (2) @(negedge clk);
            chk({tag, " R5 left"}, cap_l, sx(vl, nbits(vw)));
            chk({tag, " R5 right"}, cap_r, sx(vr, nbits(vw)));
            if (v == 0 || v == 7 || v == 9)
                chk("R7 one strobe per frame", 24'(n_valid), 24'd3);
        end

        // R8: zero-run detection, ZERO_RUN = 4
        fmt = 2'd0; wlen = 2'd3; dual = 1'b0;
        lead_in(2'd0, 1'b0);
        for (int k = 0; k < 3; k++) send_frame(2'd0, 2'd3, 1'b0, 24'h0, 24'h5);
        chk("R8 flag low after 3 zeros", {23'd0, zero_l}, 24'd0);
        send_frame(2'd0, 2'd3, 1'b0, 24'h0, 24'h5);
        chk("R8 flag high after 4 zeros", {22'd0, zero_l, zero_r}, 24'd2);
        send_frame(2'd0, 2'd3, 1'b0, 24'h0, 24'h5);
        chk("R8 flag held on more zeros", {23'd0, zero_l}, 24'd1);
        for (int k = 0; k < 4; k++) send_frame(2'd0, 2'd3, 1'b0, 24'h7, 24'h0);
        chk("R8 left clears, right sets", {22'd0, zero_l, zero_r}, 24'd1);

        // R9: reset during operation clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 left after reset", left_o, 24'h0);
        chk("R9 right after reset", right_o, 24'h0);
        chk("R9 flags after reset", {21'd0, valid_o, zero_l, zero_r}, 24'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        summary();
    end

endmodule